// File: doc/BRIEF.md
# Paged MDIO Register Access Bridge

This block turns 32-bit register reads and writes from a host into a short run of Clause-22 MDIO management frames. The target is an Ethernet switch whose internal register space can only be reached a window at a time. The window is chosen by writing a page-select register that sits at a fixed PHY address. The block drives MDC and a tri-stated MDIO line, with a separate output value, output enable and input sample.

Each host request is handled in four steps:
- Split the byte address into a 9-bit page, a 3-bit PHY offset and an even register number.
- Send the page-select frame.
- Wait a programmable settle time so that the new page takes effect.
- Move the two 16-bit halves of the data word in two more frames.

Reads fetch the lower half first. Writes send the upper half first.

The host side is a valid/ready request port with a one-cycle response pulse. Only one access is in flight at a time. The MDC half-period (`CLK_DIV` clock cycles) and the settle wait (`SETTLE_CYCLES` clock cycles) are parameters. The defaults give a slow management clock and a 1.5 ms settle time at 100 MHz.

Top module: `mdio_page_bridge`

## Requirements
- R1: Every access starts with an MDIO write frame to PHY address 0x18, register 0.
  - The data of this frame carries byte-address bits [17:9] (the page) in data bits [8:0].
  - Data bits [15:9] of this frame are zero.
- R2: The first data frame of an access begins no fewer than `SETTLE_CYCLES` clock cycles after the last MDC rising edge of the page frame.
  - It begins no more than `SETTLE_CYCLES + 4*CLK_DIV + 6` cycles after that edge.
- R3: Data frames use PHY address 0x10 OR byte-address bits [8:6].
  - The lower 16-bit half uses register number {addr[5:2], 0}.
  - The upper half uses that register number plus one.
- R4: A read sends the lower-half read frame before the upper-half read frame, and responds with rsp_rdata = {upper, lower}.
- R5: A write sends req_wdata[31:16] in the first data frame and req_wdata[15:0] in the second.
- R6: Every frame has 64 bits, in this order:
  - 32 ones;
  - start bits 0,1;
  - opcode 0,1 for a write or 1,0 for a read;
  - 5-bit PHY address, MSB first;
  - 5-bit register number, MSB first;
  - two turnaround bits;
  - 16 data bits, MSB first.

  Write frames drive MDIO for all 64 bits, with turnaround 1,0. Read frames drive bits 0 to 45 and release MDIO (mdio_oe = 0) for the turnaround and data bits 46 to 63.
- R7: On a read frame, each data bit is taken from mdio_i as MDC rises, MSB first.
- R8: req_ready is high when idle and drops in the cycle after a request is accepted. It stays low until the last frame has ended. rsp_valid is then high for exactly one cycle, in which req_ready is high again.
- R9: rsp_err is 1 with a read response whose two halves are both 0xFFFF. It is 0 for any other read, and 0 for every write response; write responses carry rsp_rdata = 0.
- R10: After reset, req_ready = 1, rsp_valid = 0, mdc = 0 and mdio_oe = 0.
- R11: While a frame runs, MDC is high for exactly `CLK_DIV` clock cycles per bit. MDC rests low between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Bridge idle and able to take a request |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 16 | Byte-address bits [17:2] of the switch register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data {upper, lower}; zero for writes |
| rsp_err | output | 1 | Read returned all ones in both halves |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input sample |

## Verification
A wrong bit counter or a wrong frame word shows up within the same 64-bit MDIO frame:
- a bad preamble, start or opcode field;
- a wrong PHY or register field;
- an output enable that drops at the wrong bit.

A wrong settle count appears at the first MDC rise of the following data frame, as a gap out of range.

A swap of the two halves, a wrong page value, or a bad error decision only appears at the port when the access completes. It shows as a mismatched rsp_rdata or rsp_err on that access's response pulse.

// File: rtl/mpb_pkg.sv
`timescale 1ns/1ps
package mpb_pkg;
  // Highest byte-address bit used by the page window split.
  localparam int ADDR_HI    = 17;
  localparam int FRAME_BITS = 64;
  localparam int TA_BIT     = 46;   // first turnaround bit
  localparam int DATA_BIT   = 48;   // first data bit

  localparam logic [4:0] PAGE_PHY      = 5'h18;
  localparam logic [4:0] DATA_PHY_BASE = 5'h10;
  localparam logic [4:0] PAGE_REG      = 5'h00;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PAGE,
    S_SETTLE,
    S_DATA0,
    S_DATA1
  } seq_state_t;

  function automatic logic [8:0] page_of(input logic [ADDR_HI:2] a);
    return a[17:9];
  endfunction

  function automatic logic [4:0] phy_of(input logic [ADDR_HI:2] a);
    return DATA_PHY_BASE | {2'b00, a[8:6]};
  endfunction

  // Even register number holding the lower half; the upper half is +1.
  function automatic logic [4:0] reg_of(input logic [ADDR_HI:2] a);
    return {a[5:2], 1'b0};
  endfunction

  function automatic logic [FRAME_BITS-1:0] frame_word(
    input logic        rd,
    input logic [4:0]  phy,
    input logic [4:0]  rg,
    input logic [15:0] data
  );
    logic [1:0]  op;
    logic [1:0]  ta;
    logic [15:0] dv;
    op = rd ? 2'b10 : 2'b01;
    ta = rd ? 2'b11 : 2'b10;
    dv = rd ? 16'hFFFF : data;
    return {32'hFFFF_FFFF, 2'b01, op, phy, rg, ta, dv};
  endfunction

  function automatic logic both_ones(input logic [15:0] hi, input logic [15:0] lo);
    return (hi == 16'hFFFF) && (lo == 16'hFFFF);
  endfunction
endpackage

// File: rtl/mpb_mdc_gen.sv
`timescale 1ns/1ps
module mpb_mdc_gen #(
  parameter int CLK_DIV = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_ev,
  output logic fall_ev
);
  localparam int CW = $clog2(CLK_DIV + 1);

  logic [CW-1:0] cnt;
  logic          phase_end;

  assign phase_end = (cnt == CW'(CLK_DIV - 1));
  // Events mark the last cycle of a phase: MDC changes at the next edge.
  assign rise_ev = run & phase_end & ~mdc;
  assign fall_ev = run & phase_end & mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (phase_end) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R11: MDC rests low once the generator is stopped
  a_r11_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc) else $error("mdc high while stopped");

  // R11: a rise event is followed by MDC high
  a_r11_rise_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev |=> mdc) else $error("mdc did not rise");
endmodule

// File: rtl/mpb_frame_shifter.sv
`timescale 1ns/1ps
module mpb_frame_shifter
  import mpb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        rd,
  input  logic [4:0]  phy,
  input  logic [4:0]  rg,
  input  logic [15:0] data,
  input  logic        rise_ev,
  input  logic        fall_ev,
  input  logic        mdio_i,
  output logic        busy,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        frame_end,
  output logic [15:0] rdata
);
  logic [FRAME_BITS-1:0] shreg;
  logic [5:0]            bitcnt;
  logic                  rd_q;
  logic                  released;

  assign released  = rd_q && (bitcnt >= 6'(TA_BIT));
  assign mdio_o    = shreg[FRAME_BITS-1];
  assign mdio_oe   = busy && !released;
  assign frame_end = busy && fall_ev && (bitcnt == 6'(FRAME_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '1;
      bitcnt <= '0;
      busy   <= 1'b0;
      rd_q   <= 1'b0;
    end else if (start) begin
      shreg  <= frame_word(rd, phy, rg, data);
      bitcnt <= '0;
      busy   <= 1'b1;
      rd_q   <= rd;
    end else if (busy && fall_ev) begin
      shreg  <= {shreg[FRAME_BITS-2:0], 1'b1};
      bitcnt <= bitcnt + 1'b1;
      if (bitcnt == 6'(FRAME_BITS - 1)) busy <= 1'b0;
    end
  end

  // Read data is taken in the last cycle of the low phase, as MDC rises.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (busy && rise_ev && rd_q && (bitcnt >= 6'(DATA_BIT))) begin
      rdata <= {rdata[14:0], mdio_i};
    end
  end

  // R6: MDIO is released mid-frame only on read frames
  a_r6_release_only_read: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mdio_oe) && busy) |-> rd_q) else $error("mdio released on a write frame");

  // R6: the first frame bit is driven
  a_r6_start_drives: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (mdio_oe && mdio_o)) else $error("preamble not driven");
endmodule

// File: rtl/mpb_access_seq.sv
`timescale 1ns/1ps
module mpb_access_seq
  import mpb_pkg::*;
#(
  parameter int SETTLE_CYCLES = 150000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_HI:2]  req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              frame_kick,
  output logic              frame_rd,
  output logic [4:0]        frame_phy,
  output logic [4:0]        frame_reg,
  output logic [15:0]       frame_data,
  input  logic              frame_end,
  input  logic [15:0]       frame_rdata
);
  localparam int SW = $clog2(SETTLE_CYCLES + 1);

  seq_state_t         state;
  logic               wr_q;
  logic [ADDR_HI:2]   addr_q;
  logic [31:0]        wdata_q;
  logic [15:0]        lo_q;
  logic [SW-1:0]      settle_cnt;

  assign req_ready = (state == S_IDLE);

  // Frame fields for the frame the current state is issuing.
  always_comb begin
    frame_rd   = 1'b0;
    frame_phy  = phy_of(addr_q);
    frame_reg  = reg_of(addr_q);
    frame_data = 16'h0000;
    unique case (state)
      S_DATA0: begin
        frame_rd = !wr_q;
        if (wr_q) begin
          frame_reg  = reg_of(addr_q) | 5'd1;
          frame_data = wdata_q[31:16];
        end
      end
      S_DATA1: begin
        frame_rd = !wr_q;
        if (wr_q) begin
          frame_data = wdata_q[15:0];
        end else begin
          frame_reg = reg_of(addr_q) | 5'd1;
        end
      end
      default: begin
        frame_phy  = PAGE_PHY;
        frame_reg  = PAGE_REG;
        frame_data = {7'b0, page_of(addr_q)};
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      wr_q       <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
      lo_q       <= '0;
      settle_cnt <= '0;
      frame_kick <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      rsp_err    <= 1'b0;
    end else begin
      frame_kick <= 1'b0;
      rsp_valid  <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (req_valid) begin
            wr_q       <= req_write;
            addr_q     <= req_addr;
            wdata_q    <= req_wdata;
            state      <= S_PAGE;
            frame_kick <= 1'b1;
          end
        end
        S_PAGE: begin
          if (frame_end) begin
            state      <= S_SETTLE;
            settle_cnt <= SW'(SETTLE_CYCLES - 1);
          end
        end
        S_SETTLE: begin
          if (settle_cnt == '0) begin
            state      <= S_DATA0;
            frame_kick <= 1'b1;
          end else begin
            settle_cnt <= settle_cnt - 1'b1;
          end
        end
        S_DATA0: begin
          if (frame_end) begin
            lo_q       <= frame_rdata;
            state      <= S_DATA1;
            frame_kick <= 1'b1;
          end
        end
        S_DATA1: begin
          if (frame_end) begin
            state     <= S_IDLE;
            rsp_valid <= 1'b1;
            rsp_rdata <= wr_q ? 32'h0 : {frame_rdata, lo_q};
            rsp_err   <= !wr_q && both_ones(frame_rdata, lo_q);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8: acceptance drops ready in the next cycle
  a_r8_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready) else $error("ready stayed high");

  // R8: the response is a single-cycle pulse
  a_r8_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid) else $error("rsp_valid longer than one cycle");

  // R2: data frames only start once the settle count has run out
  a_r2_settle_done: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DATA0 && $past(state) == S_SETTLE) |-> ($past(settle_cnt) == '0))
    else $error("settle cut short");

  // R9: the error flag never accompanies a write response
  a_r9_err_only_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> !wr_q) else $error("error on write");
endmodule

// File: rtl/mdio_page_bridge.sv
`timescale 1ns/1ps
module mdio_page_bridge
  import mpb_pkg::*;
#(
  parameter int CLK_DIV       = 20,
  parameter int SETTLE_CYCLES = 150000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [15:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        rsp_err,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic        frame_kick;
  logic        frame_rd;
  logic [4:0]  frame_phy;
  logic [4:0]  frame_reg;
  logic [15:0] frame_data;
  logic        frame_end;
  logic [15:0] frame_rdata;
  logic        shifter_busy;
  logic        rise_ev;
  logic        fall_ev;

  mpb_access_seq #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .rsp_err     (rsp_err),
    .frame_kick  (frame_kick),
    .frame_rd    (frame_rd),
    .frame_phy   (frame_phy),
    .frame_reg   (frame_reg),
    .frame_data  (frame_data),
    .frame_end   (frame_end),
    .frame_rdata (frame_rdata)
  );

  mpb_mdc_gen #(.CLK_DIV(CLK_DIV)) u_mdc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (shifter_busy),
    .mdc     (mdc),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev)
  );

  mpb_frame_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (frame_kick),
    .rd        (frame_rd),
    .phy       (frame_phy),
    .rg        (frame_reg),
    .data      (frame_data),
    .rise_ev   (rise_ev),
    .fall_ev   (fall_ev),
    .mdio_i    (mdio_i),
    .busy      (shifter_busy),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .frame_end (frame_end),
    .rdata     (frame_rdata)
  );

  // R8: the response pulse comes with the bridge idle again
  a_r8_rsp_at_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready) else $error("response while busy");

  // R10: MDIO is not driven while MDC rests and the bridge is idle
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !frame_kick) |-> !mdio_oe) else $error("mdio driven while idle");
endmodule

// File: tb/sim_mdio_page_bridge.sv
`timescale 1ns/1ps
module sim_mdio_page_bridge;
  localparam int DIV = 2;
  localparam int SET = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic        mdc;
  logic        mdio_o;
  logic        mdio_oe;
  logic        mdio_i = 1'b1;

  always #5 clk = ~clk;

  mdio_page_bridge #(.CLK_DIV(DIV), .SETTLE_CYCLES(SET)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int total = 0;
  int bad = 0;
  int hp_bad = 0;

  // expected frame: {op[1:0], phy[4:0], reg[4:0], data[15:0]}
  logic [27:0] exp_fq[$];
  // expected response: {err, rdata[31:0]}
  logic [32:0] exp_rq[$];

  task automatic chk(input bit ok, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", what, act, expv);
    end
  endtask

  // Register contents of the modelled switch, by page, PHY and register.
  function automatic logic [15:0] rdval(input logic [8:0] pg, input logic [4:0] ph,
                                        input logic [4:0] rg);
    if (pg == 9'h1FF) return 16'hFFFF;
    if (pg == 9'h1FE && rg[0]) return 16'hFFFF;
    return {pg[6:0], ph[2:0], rg, 1'b1} ^ 16'h5A3C;
  endfunction

  // ---------------- MDIO slave model and frame monitor ----------------
  int          bcnt = 0;
  logic [63:0] bits = '0;
  logic [63:0] oev = '0;
  logic [15:0] rdv = '0;
  bit          rd_act = 0;
  logic [8:0]  page_q = '0;
  bit          gap_pend = 0;
  longint      t_page = 0;
  longint      t_hi = 0;

  always @(posedge mdc) begin
    t_hi = $time;
    bits = {bits[62:0], mdio_o};
    oev  = {oev[62:0], mdio_oe};
    bcnt++;
    if (bcnt == 1 && gap_pend) begin
      longint gap;
      gap = ($time - t_page) / 10;
      gap_pend = 0;
      chk(gap >= SET && gap <= SET + 4*DIV + 6, "R2 settle gap (cycles)",
          64'(gap), 64'(SET));
    end
    if (bcnt == 46) begin
      rd_act = (bits[11:10] == 2'b10);
      rdv    = rdval(page_q, bits[9:5], bits[4:0]);
    end
    if (bcnt == 64) begin
      logic [1:0]  op;
      logic [4:0]  ph;
      logic [4:0]  rg;
      logic [15:0] dat;
      logic [63:0] oe_exp;
      logic [27:0] e;
      logic [27:0] a;
      bit          hdr_ok;
      string       tag;
      op  = bits[29:28];
      ph  = bits[27:23];
      rg  = bits[22:18];
      dat = bits[15:0];
      oe_exp = (op == 2'b10) ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
      hdr_ok = (bits[63:32] == 32'hFFFF_FFFF) && (bits[31:30] == 2'b01) &&
               (oev == oe_exp) && ((op == 2'b10) || (bits[17:16] == 2'b10));
      chk(hdr_ok, "R6 preamble/start/turnaround/oe pattern", oev, oe_exp);
      a = {op, ph, rg, (op == 2'b01) ? dat : 16'h0};
      if (exp_fq.size() == 0) begin
        chk(0, "R1 unexpected frame", 64'(a), 64'h0);
      end else begin
        e = exp_fq.pop_front();
        if (e[20:16] == 5'h18) tag = "R1 page frame";
        else if (e[27:26] == 2'b01) tag = "R5 R3 write data frame";
        else tag = "R4 R3 read frame order/address";
        chk(a == e, tag, 64'(a), 64'(e));
      end
      if (op == 2'b01 && ph == 5'h18 && rg == 5'h00) begin
        page_q   = dat[8:0];
        t_page   = $time;
        gap_pend = 1;
      end
      bcnt   = 0;
      rd_act = 0;
    end
  end

  always @(negedge mdc) begin
    if (($time - t_hi) != DIV * 10) hp_bad++;
    if (rd_act && bcnt >= 48 && bcnt <= 63) mdio_i = rdv[63 - bcnt];
    else mdio_i = 1'b1;
  end

  // ---------------- response monitor ----------------
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      logic [32:0] e;
      chk(req_ready == 1'b1, "R8 ready high with response", 64'(req_ready), 64'h1);
      if (exp_rq.size() == 0) begin
        chk(0, "R8 unexpected response", 64'(rsp_rdata), 64'h0);
      end else begin
        e = exp_rq.pop_front();
        chk(rsp_rdata == e[31:0], "R4 R7 response data", 64'(rsp_rdata), 64'(e[31:0]));
        chk(rsp_err == e[32], "R9 error flag", 64'(rsp_err), 64'(e[32]));
      end
    end
  end

  // ---------------- driver ----------------
  task automatic access(input bit wr, input logic [17:0] a, input logic [31:0] wd);
    logic [8:0]  pg;
    logic [4:0]  ph;
    logic [4:0]  rg;
    logic [15:0] lo;
    logic [15:0] hi;
    pg = a[17:9];
    ph = 5'h10 | {2'b00, a[8:6]};
    rg = {a[5:2], 1'b0};
    exp_fq.push_back({2'b01, 5'h18, 5'h00, 7'h0, pg});
    if (wr) begin
      exp_fq.push_back({2'b01, ph, rg | 5'd1, wd[31:16]});
      exp_fq.push_back({2'b01, ph, rg, wd[15:0]});
      exp_rq.push_back({1'b0, 32'h0});
    end else begin
      lo = rdval(pg, ph, rg);
      hi = rdval(pg, ph, rg | 5'd1);
      exp_fq.push_back({2'b10, ph, rg, 16'h0});
      exp_fq.push_back({2'b10, ph, rg | 5'd1, 16'h0});
      exp_rq.push_back({(hi == 16'hFFFF && lo == 16'hFFFF), hi, lo});
    end
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a[17:2];
    req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R8 ready low after accept", 64'(req_ready), 64'h0);
    while (!req_ready) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mdc == 1'b0 && mdio_oe == 1'b0,
        "R10 reset state", {60'h0, req_ready, rsp_valid, mdc, mdio_oe}, 64'h8);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    access(0, 18'h00000, 32'h0);
    access(1, 18'h3FFFC, 32'hA5C3_0F1E);
    access(0, 18'h1234C, 32'h0);
    access(1, 18'h00ABC, 32'h1234_5678);
    access(0, 18'h3FE94, 32'h0);          // both halves all ones: R9 error
    access(0, 18'h3FCA4, 32'h0);          // only upper half all ones
    access(1, 18'h3FE00, 32'hFFFF_FFFF);  // write of ones: no error
    access(0, 18'h2AAA8, 32'h0);
    access(0, 18'h155D4, 32'h0);
    repeat (20) @(negedge clk);
    chk(exp_fq.size() == 0 && exp_rq.size() == 0, "R8 all frames and responses seen",
        64'(exp_fq.size() + exp_rq.size()), 64'h0);
    chk(hp_bad == 0, "R11 MDC high phase length", 64'(hp_bad), 64'h0);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R11 MDC rests low when idle",
        {62'h0, mdc, mdio_oe}, 64'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R8 watchdog expired act=%0d exp=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule